// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block is the write-only control store behind an 8-column by 12-row analog crosspoint array. It keeps one enable bit for each of the 96 crosspoints and presents all of them at once on a 96-bit switch-enable vector. A logic 1 in a cell closes its switch and a logic 0 opens it.

A write uses a 3-bit column address, a 4-bit row address, a single data bit, an active-high chip select and an active-high strobe. Every cell is a level-sensitive latch that can be cleared. The addressed cell is open while chip select and strobe are both high. While it is open its output follows the data input. It keeps whatever the data input held when the strobe fell.

A high level on the clear input empties the whole array at once, with no clock. It overrides chip select and strobe. The block has no clock, no states and no readback path.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: The output vector has 96 bits. The bit for column c (0..7) and row r (0..11) sits at index r*8+c. A stored 1 drives that bit high (switch on) and a stored 0 drives it low (switch off).
- R2: While rst_i is low and cs_i and stb_i are both high, the addressed bit follows data_i and changes whenever data_i changes.
- R3: The addressed bit keeps the value data_i had when stb_i fell. Later changes of data_i have no effect on it.
- R4: A write alters only the addressed bit. The other 95 bits keep their previous values.
- R5: With cs_i low, a strobe pulse leaves every output bit unchanged.
- R6: Row addresses 12 through 15 select no cell. A strobed write with one of these codes leaves every output bit unchanged.
- R7: A high rst_i drives all 96 output bits to 0 at once, without a clock, whatever the levels of cs_i and stb_i.
- R8: While rst_i is high, a strobed write with cs_i high leaves every output bit at 0.
- R9: With stb_i low, changes on data_i, col_addr_i and row_addr_i leave every output bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_i | input | 1 | Clears the whole array without a clock, active high |
| cs_i | input | 1 | Chip select, active high |
| stb_i | input | 1 | Write strobe. The cell is open while high and holds on the falling edge |
| data_i | input | 1 | Value written to the addressed cell (1 = switch on) |
| col_addr_i | input | 3 | Column address 0..7 |
| row_addr_i | input | 4 | Row address 0..11. Codes 12..15 select nothing |
| sw_en_o | output | 96 | Switch enables. Bit r*8+c belongs to column c, row r |

## Verification
The bench aims at the edges of the index mapping: cell 0 and cell 95, plus mid-array cells. A swapped row/column multiply would land these on the wrong bits. It toggles data while the strobe is high and again after the strobe has fallen. A cell that loads on an edge instead of being transparent fails the first part, and a cell that never closes fails the second. The bench writes with row codes 12 through 15, strobes with chip select low and raises clear in the middle of a strobed write. A decoder that wraps the high row codes, ignores chip select or lets a write beat the clear then shows stray set bits.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    localparam int unsigned XPT_COLS = 8;
    localparam int unsigned XPT_ROWS = 12;
    localparam int unsigned XPT_CAW  = $clog2(XPT_COLS);
    localparam int unsigned XPT_RAW  = $clog2(XPT_ROWS);
    localparam int unsigned XPT_CELLS = XPT_COLS * XPT_ROWS;
endpackage

// File: rtl/xpt_addr_dec.sv
module xpt_addr_dec #(
    parameter int unsigned COLS = xpt_pkg::XPT_COLS,
    parameter int unsigned ROWS = xpt_pkg::XPT_ROWS,
    parameter int unsigned CAW  = $clog2(COLS),
    parameter int unsigned RAW  = $clog2(ROWS)
) (
    input  logic            cs_i,
    input  logic            stb_i,
    input  logic [CAW-1:0]  col_addr_i,
    input  logic [RAW-1:0]  row_addr_i,
    output logic [COLS-1:0] col_hit_o,
    output logic [ROWS-1:0] row_open_o
);
    logic wr_gate;

    assign wr_gate = cs_i & stb_i;

    for (genvar gc = 0; gc < COLS; gc++) begin : g_col
        assign col_hit_o[gc] = (col_addr_i == CAW'(gc));
    end

    // Codes at or above ROWS match no row, so those writes fall through.
    for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
        assign row_open_o[gr] = wr_gate & (row_addr_i == RAW'(gr));
    end
endmodule

// File: rtl/xpt_cell.sv
module xpt_cell (
    input  logic rst_i,
    input  logic en_i,
    input  logic d_i,
    output logic q_o
);
    always_latch begin
        if (rst_i) begin
            q_o <= 1'b0;
        end else if (en_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem #(
    parameter int unsigned COLS = xpt_pkg::XPT_COLS,
    parameter int unsigned ROWS = xpt_pkg::XPT_ROWS,
    localparam int unsigned CAW = $clog2(COLS),
    localparam int unsigned RAW = $clog2(ROWS),
    localparam int unsigned NCELL = COLS * ROWS
) (
    input  logic             rst_i,
    input  logic             cs_i,
    input  logic             stb_i,
    input  logic             data_i,
    input  logic [CAW-1:0]   col_addr_i,
    input  logic [RAW-1:0]   row_addr_i,
    output logic [NCELL-1:0] sw_en_o
);
    logic [COLS-1:0] col_hit;
    logic [ROWS-1:0] row_open;

    xpt_addr_dec #(
        .COLS(COLS),
        .ROWS(ROWS),
        .CAW (CAW),
        .RAW (RAW)
    ) dec_i (
        .cs_i      (cs_i),
        .stb_i     (stb_i),
        .col_addr_i(col_addr_i),
        .row_addr_i(row_addr_i),
        .col_hit_o (col_hit),
        .row_open_o(row_open)
    );

    for (genvar gr = 0; gr < ROWS; gr++) begin : g_r
        for (genvar gc = 0; gc < COLS; gc++) begin : g_c
            xpt_cell cell_i (
                .rst_i(rst_i),
                .en_i (row_open[gr] & col_hit[gc]),
                .d_i  (data_i),
                .q_o  (sw_en_o[gr*COLS+gc])
            );
        end
    end
endmodule

// Sampling checker: the block has no clock, so it observes the ports on
// the edges of a clock supplied by the environment that instantiates it.
module xpt_ctrl_mem_chk #(
    parameter int unsigned COLS = xpt_pkg::XPT_COLS,
    parameter int unsigned ROWS = xpt_pkg::XPT_ROWS,
    localparam int unsigned CAW = $clog2(COLS),
    localparam int unsigned RAW = $clog2(ROWS),
    localparam int unsigned NCELL = COLS * ROWS
) (
    input logic             smp_clk,
    input logic             rst_i,
    input logic             cs_i,
    input logic             stb_i,
    input logic             data_i,
    input logic [CAW-1:0]   col_addr_i,
    input logic [RAW-1:0]   row_addr_i,
    input logic [NCELL-1:0] sw_en_o
);
    logic row_ok;
    int unsigned sel_idx;

    assign row_ok  = (32'(row_addr_i) < ROWS);
    assign sel_idx = 32'(row_addr_i) * COLS + 32'(col_addr_i);

    // R7
    always_ff @(posedge smp_clk) begin
        if (rst_i) begin
            rst_clear_chk: assert (sw_en_o == '0);
        end
    end

    // R2
    open_follow_chk: assert property (@(posedge smp_clk) disable iff (rst_i)
        (cs_i && stb_i && row_ok) |-> (sw_en_o[sel_idx] == data_i));

    // R5
    closed_hold_chk: assert property (@(posedge smp_clk) disable iff (rst_i)
        (!$past(rst_i) && !(cs_i && stb_i) && !$past(cs_i && stb_i)) |-> $stable(sw_en_o));

    // R6
    bad_row_chk: assert property (@(posedge smp_clk) disable iff (rst_i)
        (!$past(rst_i) && !row_ok && !$past(row_ok)) |-> $stable(sw_en_o));

    // R4
    single_bit_chk: assert property (@(posedge smp_clk) disable iff (rst_i)
        !$past(rst_i) |-> ($countones(sw_en_o ^ $past(sw_en_o)) <= 1));
endmodule

// File: tb/xpt_ctrl_mem_tb_top.sv
module xpt_ctrl_mem_tb_top;
    localparam int unsigned NC = 8;
    localparam int unsigned NR = 12;
    localparam int unsigned NB = NC * NR;
    localparam int unsigned NV = 10;

    // each entry: {col[2:0], row[3:0], data}
    localparam logic [7:0] VEC [NV] = '{
        {3'd0, 4'd0,  1'b1},
        {3'd7, 4'd11, 1'b1},
        {3'd3, 4'd5,  1'b1},
        {3'd3, 4'd5,  1'b0},
        {3'd7, 4'd0,  1'b1},
        {3'd0, 4'd11, 1'b1},
        {3'd2, 4'd13, 1'b1},
        {3'd5, 4'd15, 1'b1},
        {3'd7, 4'd11, 1'b0},
        {3'd4, 4'd6,  1'b1}
    };

    logic          clk = 1'b0;
    logic          rst, cs, stb, dat;
    logic [2:0]    col;
    logic [3:0]    row;
    logic [NB-1:0] sw_en;
    logic [NB-1:0] model;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    xpt_ctrl_mem dut_i (
        .rst_i(rst), .cs_i(cs), .stb_i(stb), .data_i(dat),
        .col_addr_i(col), .row_addr_i(row), .sw_en_o(sw_en)
    );

    xpt_ctrl_mem_chk chk_i (
        .smp_clk(clk), .rst_i(rst), .cs_i(cs), .stb_i(stb), .data_i(dat),
        .col_addr_i(col), .row_addr_i(row), .sw_en_o(sw_en)
    );

    task automatic check(input string req, input logic [NB-1:0] exp);
        checks++;
        if (sw_en !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, sw_en, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    task automatic do_write(input logic [2:0] c, input logic [3:0] r,
                            input logic d, input logic sel);
        @(negedge clk); col = c; row = r; dat = d; cs = sel;
        @(negedge clk); stb = 1'b1;
        @(negedge clk); stb = 1'b0;
        @(negedge clk); cs = 1'b0;
    endtask

    initial begin
        rst = 1'b1; cs = 1'b0; stb = 1'b0; dat = 1'b0; col = '0; row = '0;
        model = '0;
        settle();
        check("R7 reset state", '0);
        @(negedge clk); rst = 1'b0;
        settle();
        check("R7 after release", '0);

        // R1 R4 R6: table of writes compared against the bench model
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][7:5], VEC[i][4:1], VEC[i][0], 1'b1);
            if (VEC[i][4:1] < NR)
                model[VEC[i][4:1]*NC + VEC[i][7:5]] = VEC[i][0];
            settle();
            check(VEC[i][4:1] < NR ? "R1 R4 table write" : "R6 dead row", model);
        end

        // R5: strobe with chip select low
        do_write(3'd1, 4'd1, 1'b1, 1'b0);
        settle();
        check("R5 cs low", model);

        // R9: address and data move with strobe low and cs high
        @(negedge clk); cs = 1'b1; col = 3'd6; row = 4'd9; dat = 1'b1;
        @(negedge clk); col = 3'd2; row = 4'd2; dat = 1'b0;
        settle();
        check("R9 strobe low", model);

        // R2: transparency on cell row 2 col 2 (index 18)
        @(negedge clk); dat = 1'b1; stb = 1'b1;
        model[18] = 1'b1;
        settle();
        check("R2 open follows 1", model);
        @(negedge clk); dat = 1'b0;
        model[18] = 1'b0;
        settle();
        check("R2 open follows 0", model);
        @(negedge clk); dat = 1'b1;
        model[18] = 1'b1;
        settle();
        // R3: close with 1, then data drops
        @(negedge clk); stb = 1'b0;
        @(negedge clk); dat = 1'b0;
        settle();
        check("R3 held after fall", model);
        @(negedge clk); cs = 1'b0;

        // R7: clear with cs and stb high, mid-write
        @(negedge clk); col = 3'd5; row = 4'd4; dat = 1'b1; cs = 1'b1;
        @(negedge clk); stb = 1'b1;
        model[37] = 1'b1;
        settle();
        check("R2 before clear", model);
        @(negedge clk); rst = 1'b1;
        model = '0;
        #2;
        check("R7 async clear", model);
        // R8: data toggles under clear with strobe still high
        @(negedge clk); dat = 1'b0;
        @(negedge clk); dat = 1'b1;
        settle();
        check("R8 write blocked", model);
        @(negedge clk); stb = 1'b0; cs = 1'b0;
        @(negedge clk); rst = 1'b0;
        settle();
        check("R8 after release", model);

        // R1: far corner alone
        do_write(3'd7, 4'd11, 1'b1, 1'b1);
        model[95] = 1'b1;
        settle();
        check("R1 top index", model);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule